// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Comparator Unit

This block holds a set of instruction breakpoints and data watchpoints that a debugger programs over an APB register slave with zero wait states. Every cycle it looks at the instruction fetch address, the data access address with its byte enables and direction, and the current process context identifier and virtual machine identifier. When an enabled unit matches, it raises a registered hit flag together with the index of the matching unit. When several units match, the lowest index wins.

There are six breakpoint pairs. Each pair has a value register and a control register. The first four pairs compare only against the fetch address. The last two may instead compare the context identifier or the VMID. A pair set to one of those context modes never raises a hit of its own. It serves as a qualifier that a watchpoint can link to, so that a data match traps only inside the chosen process or virtual machine. There are four watchpoints. Each one covers a doubleword with a byte-lane mask and selects loads, stores or both.

There are two resets. A cold reset clears all programmed state. A warm reset only silences the hit outputs and leaves the debugger's settings in place.

Top module: `dbgw_unit`

## Requirements
- R1: A cold reset (`rst` high at a clock edge) clears every breakpoint and watchpoint register, `prdata`, and both hit outputs. All programmed registers then read back as zero.
- R2: A warm reset (`warm_rst`) leaves every register unchanged. Both hit outputs and both index outputs are zero in the cycle after a clock edge at which `warm_rst` was high.
- R3: Register map, with word offsets in an 8-bit byte address. Breakpoint values sit at 0x00+4n, breakpoint controls at 0x40+4n, watchpoint values at 0x80+4n and watchpoint controls at 0xC0+4n. A write takes effect at the access-phase edge. Read data is valid during the access phase. Entries past the implemented count read zero and ignore writes.
- R4: An enabled breakpoint in address mode hits when `i_valid` is high and `i_addr[31:2]` equals `value[31:2]`. A disabled breakpoint never hits.
- R5: Breakpoint control layout: bit 0 is enable and bits [2:1] are the match type (0 = address, 1 = context ID, 2 = VMID). Any nonzero type written to pairs 0 to 3, and type 3 written to any pair, is stored and read back as 0.
- R6: A breakpoint pair in context ID or VMID mode never raises `bp_hit`, whatever the fetch address or context.
- R7: Watchpoint control layout: bit 0 is enable, bits [2:1] are the access select (bit 1 = loads, bit 2 = stores), bits [11:4] are the byte mask, bit 12 is link enable and bit 13 is link select. Bit 3 and bits above 13 read zero. An enabled watchpoint hits on a `d_valid` access when the direction is selected, `d_addr[31:3]` equals `value[31:3]`, and `d_be & mask` is nonzero.
- R8: A linked watchpoint also needs its target pair to be enabled and in context mode with a matching comparison. Link select 0 names pair 4 and 1 names pair 5. Type 1 compares `ctx_id` with all 32 value bits. Type 2 compares `vmid` with value bits [15:0].
- R9: When several units of one kind match, the index output gives the lowest-numbered one. The index output is zero when its hit flag is low.
- R10: `bp_hit`/`bp_idx` and `wp_hit`/`wp_idx` are registered. They reflect the fetch or access presented at one clock edge and are valid for exactly the cycle that follows. Both kinds can assert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high; clears only hit outputs |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in access phase |
| i_valid | input | 1 | Instruction fetch present |
| i_addr | input | 32 | Instruction fetch virtual address |
| d_valid | input | 1 | Data access present |
| d_write | input | 1 | Data access is a store (else a load) |
| d_addr | input | 32 | Data access virtual address |
| d_be | input | 8 | Byte enables within the addressed doubleword |
| ctx_id | input | 32 | Current context identifier |
| vmid | input | 16 | Current virtual machine identifier |
| bp_hit | output | 1 | Breakpoint hit, one cycle after the fetch |
| bp_idx | output | 3 | Lowest matching breakpoint index |
| wp_hit | output | 1 | Watchpoint hit, one cycle after the access |
| wp_idx | output | 2 | Lowest matching watchpoint index |

## Verification
A fetch or data access driven before a clock edge shows up on `bp_hit`/`wp_hit` and their indices in the cycle that follows. The bench model computes the expected flags at that same edge from its own copy of the programmed registers and compares them with the outputs half a period later, on every cycle. A register write counts from its access-phase edge, so the model applies it after it evaluates that edge. APB read data is checked in the access phase, one cycle after the setup phase that captured it. The model zeroes its expected hits on any edge where either reset is high.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  typedef enum logic [1:0] {
    MT_ADDR  = 2'd0,
    MT_CTXID = 2'd1,
    MT_VMID  = 2'd2
  } match_t;

  localparam int          PADDR_W  = 8;
  localparam logic [1:0]  BANK_BPV = 2'd0;
  localparam logic [1:0]  BANK_BPC = 2'd1;
  localparam logic [1:0]  BANK_WPV = 2'd2;
  localparam logic [1:0]  BANK_WPC = 2'd3;
  localparam int          BE_W     = 8;
endpackage

// File: rtl/dbgw_regs.sv
module dbgw_regs
  import dbgw_pkg::*;
#(
  parameter int NUM_BP     = 6,
  parameter int NUM_CTX_BP = 2,
  parameter int NUM_WP     = 4,
  parameter int AW         = 32,
  parameter int LSEL_W     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [AW-1:0]      pwdata,
  output logic [AW-1:0]      prdata,
  output logic [AW-1:0]      bp_val  [NUM_BP],
  output logic               bp_en   [NUM_BP],
  output match_t             bp_type [NUM_BP],
  output logic [AW-1:0]      wp_val  [NUM_WP],
  output logic               wp_en   [NUM_WP],
  output logic [1:0]         wp_sel  [NUM_WP],
  output logic [BE_W-1:0]    wp_mask [NUM_WP],
  output logic               wp_link [NUM_WP],
  output logic [LSEL_W-1:0]  wp_lsel [NUM_WP]
);
  localparam int CTX_FIRST = NUM_BP - NUM_CTX_BP;

  logic       wr_en;
  logic [1:0] bank;
  logic [3:0] idx;
  logic [AW-1:0] rd_mux;
  logic       unused_addr;

  assign wr_en       = psel & penable & pwrite;
  assign bank        = paddr[7:6];
  assign idx         = paddr[5:2];
  assign unused_addr = ^paddr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BP; i++) begin
        bp_val[i]  <= '0;
        bp_en[i]   <= 1'b0;
        bp_type[i] <= MT_ADDR;
      end
      for (int j = 0; j < NUM_WP; j++) begin
        wp_val[j]  <= '0;
        wp_en[j]   <= 1'b0;
        wp_sel[j]  <= '0;
        wp_mask[j] <= '0;
        wp_link[j] <= 1'b0;
        wp_lsel[j] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (idx == 4'(i)) begin
          if (bank == BANK_BPV) bp_val[i] <= pwdata;
          if (bank == BANK_BPC) begin
            bp_en[i]   <= pwdata[0];
            bp_type[i] <= (i >= CTX_FIRST && pwdata[2:1] != 2'd3)
                          ? match_t'(pwdata[2:1]) : MT_ADDR;
          end
        end
      end
      for (int j = 0; j < NUM_WP; j++) begin
        if (idx == 4'(j)) begin
          if (bank == BANK_WPV) wp_val[j] <= pwdata;
          if (bank == BANK_WPC) begin
            wp_en[j]   <= pwdata[0];
            wp_sel[j]  <= pwdata[2:1];
            wp_mask[j] <= pwdata[4 +: BE_W];
            wp_link[j] <= pwdata[12];
            wp_lsel[j] <= pwdata[13 +: LSEL_W];
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (idx == 4'(i) && bank == BANK_BPV) rd_mux = bp_val[i];
      if (idx == 4'(i) && bank == BANK_BPC) rd_mux = AW'({bp_type[i], bp_en[i]});
    end
    for (int j = 0; j < NUM_WP; j++) begin
      if (idx == 4'(j) && bank == BANK_WPV) rd_mux = wp_val[j];
      if (idx == 4'(j) && bank == BANK_WPC)
        rd_mux = AW'({wp_lsel[j], wp_link[j], wp_mask[j], 1'b0, wp_sel[j], wp_en[j]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              prdata <= '0;
    else if (psel && !penable && !pwrite) prdata <= rd_mux;
  end
endmodule

// File: rtl/dbgw_bp_cmp.sv
module dbgw_bp_cmp
  import dbgw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CTX_W  = 32,
  parameter int VMID_W = 16
) (
  input  logic              en,
  input  match_t            mtype,
  input  logic [AW-1:0]     val,
  input  logic              i_valid,
  input  logic [AW-1:0]     i_addr,
  input  logic [CTX_W-1:0]  ctx_id,
  input  logic [VMID_W-1:0] vmid,
  output logic              addr_hit,
  output logic              ctx_ok
);
  logic unused_low;
  assign unused_low = ^i_addr[1:0];

  assign addr_hit = en && (mtype == MT_ADDR) && i_valid
                    && (i_addr[AW-1:2] == val[AW-1:2]);
  assign ctx_ok   = en && (((mtype == MT_CTXID) && (ctx_id == val[CTX_W-1:0]))
                        || ((mtype == MT_VMID)  && (vmid   == val[VMID_W-1:0])));
endmodule

// File: rtl/dbgw_wp_cmp.sv
module dbgw_wp_cmp
  import dbgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            en,
  input  logic [1:0]      sel,
  input  logic [BE_W-1:0] mask,
  input  logic            link,
  input  logic            link_ok,
  input  logic [AW-1:0]   val,
  input  logic            d_valid,
  input  logic            d_write,
  input  logic [AW-1:0]   d_addr,
  input  logic [BE_W-1:0] d_be,
  output logic            hit
);
  logic dir_ok;
  logic unused_low;
  assign unused_low = ^{d_addr[2:0], val[2:0]};
  assign dir_ok     = d_write ? sel[1] : sel[0];

  assign hit = en && d_valid && dir_ok
               && (d_addr[AW-1:3] == val[AW-1:3])
               && (|(d_be & mask))
               && (!link || link_ok);
endmodule

// File: rtl/dbgw_unit.sv
module dbgw_unit
  import dbgw_pkg::*;
#(
  parameter int NUM_BP     = 6,
  parameter int NUM_CTX_BP = 2,
  parameter int NUM_WP     = 4,
  parameter int AW         = 32,
  parameter int CTX_W      = 32,
  parameter int VMID_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      warm_rst,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [7:0]                paddr,
  input  logic [AW-1:0]             pwdata,
  output logic [AW-1:0]             prdata,
  input  logic                      i_valid,
  input  logic [AW-1:0]             i_addr,
  input  logic                      d_valid,
  input  logic                      d_write,
  input  logic [AW-1:0]             d_addr,
  input  logic [7:0]                d_be,
  input  logic [CTX_W-1:0]          ctx_id,
  input  logic [VMID_W-1:0]         vmid,
  output logic                      bp_hit,
  output logic [$clog2(NUM_BP)-1:0] bp_idx,
  output logic                      wp_hit,
  output logic [$clog2(NUM_WP)-1:0] wp_idx
);
  localparam int CTX_FIRST = NUM_BP - NUM_CTX_BP;
  localparam int LSEL_W    = (NUM_CTX_BP > 1) ? $clog2(NUM_CTX_BP) : 1;
  localparam int BPI_W     = $clog2(NUM_BP);
  localparam int WPI_W     = $clog2(NUM_WP);

  logic [AW-1:0]     bp_val  [NUM_BP];
  logic              bp_en   [NUM_BP];
  match_t            bp_type [NUM_BP];
  logic [AW-1:0]     wp_val  [NUM_WP];
  logic              wp_en   [NUM_WP];
  logic [1:0]        wp_sel  [NUM_WP];
  logic [BE_W-1:0]   wp_mask [NUM_WP];
  logic              wp_link [NUM_WP];
  logic [LSEL_W-1:0] wp_lsel [NUM_WP];

  logic [NUM_BP-1:0] bp_addr_hit;
  logic [NUM_BP-1:0] bp_ctx_ok;
  logic [NUM_WP-1:0] wp_raw_hit;
  logic [NUM_WP-1:0] wp_link_ok;
  logic [BPI_W-1:0]  bp_first;
  logic [WPI_W-1:0]  wp_first;

  dbgw_regs #(
    .NUM_BP(NUM_BP), .NUM_CTX_BP(NUM_CTX_BP), .NUM_WP(NUM_WP),
    .AW(AW), .LSEL_W(LSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .bp_val(bp_val), .bp_en(bp_en), .bp_type(bp_type),
    .wp_val(wp_val), .wp_en(wp_en), .wp_sel(wp_sel), .wp_mask(wp_mask),
    .wp_link(wp_link), .wp_lsel(wp_lsel)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dbgw_bp_cmp #(.AW(AW), .CTX_W(CTX_W), .VMID_W(VMID_W)) u_cmp (
      .en(bp_en[i]), .mtype(bp_type[i]), .val(bp_val[i]),
      .i_valid(i_valid), .i_addr(i_addr), .ctx_id(ctx_id), .vmid(vmid),
      .addr_hit(bp_addr_hit[i]), .ctx_ok(bp_ctx_ok[i])
    );
  end

  always_comb begin
    for (int j = 0; j < NUM_WP; j++) begin
      wp_link_ok[j] = 1'b0;
      for (int k = 0; k < NUM_CTX_BP; k++)
        if (wp_lsel[j] == LSEL_W'(k)) wp_link_ok[j] = bp_ctx_ok[CTX_FIRST + k];
    end
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    dbgw_wp_cmp #(.AW(AW)) u_cmp (
      .en(wp_en[j]), .sel(wp_sel[j]), .mask(wp_mask[j]),
      .link(wp_link[j]), .link_ok(wp_link_ok[j]), .val(wp_val[j]),
      .d_valid(d_valid), .d_write(d_write), .d_addr(d_addr), .d_be(d_be),
      .hit(wp_raw_hit[j])
    );
  end

  always_comb begin
    bp_first = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (bp_addr_hit[i]) bp_first = BPI_W'(i);
    wp_first = '0;
    for (int j = NUM_WP - 1; j >= 0; j--)
      if (wp_raw_hit[j]) wp_first = WPI_W'(j);
  end

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      bp_hit <= 1'b0;
      bp_idx <= '0;
      wp_hit <= 1'b0;
      wp_idx <= '0;
    end else begin
      bp_hit <= |bp_addr_hit;
      bp_idx <= bp_first;
      wp_hit <= |wp_raw_hit;
      wp_idx <= wp_first;
    end
  end
endmodule

// File: rtl/dbgw_chk.sv
module dbgw_chk #(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      warm_rst,
  input logic                      i_valid,
  input logic                      d_valid,
  input logic [7:0]                d_be,
  input logic                      bp_hit,
  input logic [$clog2(NUM_BP)-1:0] bp_idx,
  input logic                      wp_hit,
  input logic [$clog2(NUM_WP)-1:0] wp_idx
);
  assert_bp_follows_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> $past(i_valid));
  assert_wp_follows_access_R10: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> $past(d_valid));
  assert_warm_silences_R2: assert property (@(posedge clk) disable iff (rst)
    $past(warm_rst) |-> (!bp_hit && !wp_hit && bp_idx == '0 && wp_idx == '0));
  assert_bp_idx_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bp_hit |-> bp_idx == '0);
  assert_wp_idx_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !wp_hit |-> wp_idx == '0);
  assert_bp_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> int'(bp_idx) < NUM_BP);
  assert_wp_lane_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    wp_hit |-> $past(d_be) != 8'h00);
endmodule

bind dbgw_unit dbgw_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .i_valid(i_valid),
  .d_valid(d_valid), .d_be(d_be), .bp_hit(bp_hit), .bp_idx(bp_idx),
  .wp_hit(wp_hit), .wp_idx(wp_idx)
);

// File: tb/sim_dbgw_unit.sv
module sim_dbgw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1, warm_rst = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        i_valid = 1'b0, d_valid = 1'b0, d_write = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0, ctx_id = '0;
  logic [7:0]  d_be = '0;
  logic [15:0] vmid = '0;
  logic        bp_hit, wp_hit;
  logic [2:0]  bp_idx;
  logic [1:0]  wp_idx;

  dbgw_unit u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .i_valid(i_valid), .i_addr(i_addr), .d_valid(d_valid), .d_write(d_write),
    .d_addr(d_addr), .d_be(d_be), .ctx_id(ctx_id), .vmid(vmid),
    .bp_hit(bp_hit), .bp_idx(bp_idx), .wp_hit(wp_hit), .wp_idx(wp_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic started = 1'b0;

  // Behavioural model: stored register images and expected hits
  logic [31:0] m_bpv [6];
  logic [31:0] m_bpc [6];
  logic [31:0] m_wpv [4];
  logic [31:0] m_wpc [4];
  logic        e_bp, e_wp;
  int          e_bpi, e_wpi;

  function automatic logic ctx_match(int p);
    logic [1:0] t;
    t = m_bpc[p][2:1];
    return m_bpc[p][0] && ((t == 2'd1 && ctx_id == m_bpv[p]) ||
                           (t == 2'd2 && vmid == m_bpv[p][15:0]));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin m_bpv[i] = 0; m_bpc[i] = 0; end
      for (int j = 0; j < 4; j++) begin m_wpv[j] = 0; m_wpc[j] = 0; end
      e_bp = 0; e_bpi = 0; e_wp = 0; e_wpi = 0;
    end else begin
      e_bp = 0; e_bpi = 0; e_wp = 0; e_wpi = 0;
      for (int i = 5; i >= 0; i--)
        if (m_bpc[i][0] && m_bpc[i][2:1] == 2'd0 && i_valid &&
            (i_addr >> 2) == (m_bpv[i] >> 2)) begin e_bp = 1; e_bpi = i; end
      for (int j = 3; j >= 0; j--) begin
        logic [31:0] c;
        logic ok;
        c = m_wpc[j];
        ok = c[0] && d_valid && (d_write ? c[2] : c[1]) &&
             (d_addr >> 3) == (m_wpv[j] >> 3) && ((d_be & c[11:4]) != 0) &&
             (!c[12] || ctx_match(c[13] ? 5 : 4));
        if (ok) begin e_wp = 1; e_wpi = j; end
      end
      if (warm_rst) begin e_bp = 0; e_bpi = 0; e_wp = 0; e_wpi = 0; end
      if (psel && penable && pwrite) begin
        int n;
        n = int'(paddr[5:2]);
        case (paddr[7:6])
          2'd0: if (n < 6) m_bpv[n] = pwdata;
          2'd1: if (n < 6) m_bpc[n] = {29'd0,
                  ((n >= 4 && pwdata[2:1] != 2'd3) ? pwdata[2:1] : 2'd0), pwdata[0]};
          2'd2: if (n < 4) m_wpv[n] = pwdata;
          default: if (n < 4) m_wpc[n] = pwdata & 32'h0000_3FF7;
        endcase
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (bp_hit !== e_bp || (e_bp && int'(bp_idx) != e_bpi) || (!e_bp && bp_idx !== 3'd0)) begin
        n_bad++;
        $display("FAIL %s bp: hit=%0d idx=%0d expected hit=%0d idx=%0d",
                 cur_req, bp_hit, bp_idx, e_bp, e_bpi);
      end
      n_cmp++;
      if (wp_hit !== e_wp || (e_wp && int'(wp_idx) != e_wpi) || (!e_wp && wp_idx !== 2'd0)) begin
        n_bad++;
        $display("FAIL %s wp: hit=%0d idx=%0d expected hit=%0d idx=%0d",
                 cur_req, wp_hit, wp_idx, e_wp, e_wpi);
      end
    end
  end

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    n_cmp++;
    if (prdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", req, a, prdata, exp);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk); i_valid = 1; i_addr = a;
    @(negedge clk); i_valid = 0;
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [7:0] be);
    @(negedge clk); d_valid = 1; d_write = wr; d_addr = a; d_be = be;
    @(negedge clk); d_valid = 0; d_be = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    cur_req = "R1";
    apb_read(8'h00, 32'h0, "R1");
    apb_read(8'h40, 32'h0, "R1");
    apb_read(8'hC0, 32'h0, "R1");

    // R4: address breakpoints
    cur_req = "R4";
    apb_write(8'h00, 32'h0000_1000);
    apb_write(8'h40, 32'h1);
    apb_read(8'h00, 32'h0000_1000, "R3");
    apb_read(8'h40, 32'h1, "R4");
    fetch(32'h1000); fetch(32'h1002); fetch(32'h1004); fetch(32'h0FFC);
    apb_write(8'h40, 32'h0);
    fetch(32'h1000);
    apb_write(8'h40, 32'h1);

    // R9: breakpoint priority
    cur_req = "R9";
    apb_write(8'h04, 32'h2000); apb_write(8'h08, 32'h2000);
    apb_write(8'h44, 32'h1);    apb_write(8'h48, 32'h1);
    fetch(32'h2000);
    apb_write(8'h44, 32'h0);
    fetch(32'h2000);

    // R5: match type legality
    cur_req = "R5";
    apb_write(8'h44, 32'h3); apb_read(8'h44, 32'h1, "R5");
    apb_write(8'h50, 32'h7); apb_read(8'h50, 32'h1, "R5");
    apb_write(8'h50, 32'h3); apb_read(8'h50, 32'h3, "R5");
    fetch(32'h2000);

    // R6: context pair never hits alone
    cur_req = "R6";
    apb_write(8'h10, 32'h55);
    ctx_id = 32'h55;
    fetch(32'h55); fetch(32'h54); fetch(32'h0);

    // R3: unimplemented entries
    cur_req = "R3";
    apb_write(8'h1C, 32'hDEAD_BEEF); apb_read(8'h1C, 32'h0, "R3");
    apb_write(8'hD4, 32'hFFFF_FFFF); apb_read(8'hD4, 32'h0, "R3");

    // R7: watchpoints
    cur_req = "R7";
    apb_write(8'hCC, 32'hFFFF_FFFF); apb_read(8'hCC, 32'h0000_3FF7, "R7");
    apb_write(8'hCC, 32'h0);
    apb_write(8'h80, 32'h3000);
    apb_write(8'hC0, 32'h0000_00F3);
    access(0, 32'h3000, 8'h01);
    access(0, 32'h3000, 8'hF0);
    access(1, 32'h3000, 8'h01);
    access(0, 32'h3008, 8'h01);
    access(0, 32'h3004, 8'h01);

    // R8: linking
    cur_req = "R8";
    apb_write(8'h84, 32'h3000);
    apb_write(8'hC4, 32'h0000_1FF7);
    access(1, 32'h3000, 8'h80);
    ctx_id = 32'h66;
    access(1, 32'h3000, 8'h80);
    ctx_id = 32'h55;
    apb_write(8'h14, 32'h7);
    apb_write(8'h54, 32'h5);
    apb_write(8'h88, 32'h4000);
    apb_write(8'hC8, 32'h0000_3FF3);
    vmid = 16'd7; access(0, 32'h4000, 8'h10);
    vmid = 16'd8; access(0, 32'h4000, 8'h10);
    apb_write(8'h50, 32'h1);
    access(1, 32'h3000, 8'h80);
    apb_write(8'h50, 32'h3);

    // R9: watchpoint priority
    cur_req = "R9";
    access(0, 32'h3000, 8'h01);

    // R10: simultaneous fetch and access
    cur_req = "R10";
    @(negedge clk); i_valid = 1; i_addr = 32'h1000; d_valid = 1; d_write = 1;
    d_addr = 32'h3000; d_be = 8'hFF;
    @(negedge clk); i_valid = 0; d_valid = 0; d_be = 0;
    @(negedge clk);

    // R2: warm reset
    cur_req = "R2";
    @(negedge clk); warm_rst = 1; i_valid = 1; i_addr = 32'h1000;
    @(negedge clk); warm_rst = 0; i_valid = 0;
    apb_read(8'h00, 32'h0000_1000, "R2");
    apb_read(8'hC4, 32'h0000_1FF7, "R2");
    fetch(32'h1000);

    // R1: cold reset clears everything
    cur_req = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    apb_read(8'h00, 32'h0, "R1");
    apb_read(8'h50, 32'h0, "R1");
    apb_read(8'hC4, 32'h0, "R1");
    fetch(32'h1000);
    access(1, 32'h3000, 8'hFF);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule